// File: doc/BRIEF.md
# Accumulator Execute Unit

This block is the execute stage of a 32-bit accumulator machine. It holds a single accumulator and, on each clock edge where the write-enable is high, replaces its value with the result of a decoded operation. The second operand is either a register-file value or an 8-bit immediate.

The operations are add and subtract, and, or, xor, a one-bit arithmetic right shift, and loads from a register or an immediate. Three partial loads write a sign-extended immediate into the upper part of the accumulator, starting at byte 1, 2 or 3, and keep every bit below that point. A 32-bit constant can be built this way in a few steps. The store-to-register operation does not change the accumulator. It presents the accumulator as write-back data, together with a write strobe.

Registered zero and sign flags follow the accumulator so that branch logic can use them. Instruction fetch, decoding of raw instruction bits, memory access and branching belong to other blocks.

Top module: `acc_exec`

## Requirements
- R1: While `rst_n` is low and after its release, the accumulator reads 0, `zero_o` reads 1 and `neg_o` reads 0, until the first enabled update.
- R2: The accumulator changes only on a rising clock edge where `we_i` is 1. With `we_i` at 0 it holds its value whatever `op_code_i` carries.
- R3: Code 1 (add) sets A to A + rn, and code 3 (sub) sets A to A - rn. Both wrap modulo 2^32.
- R4: Code 2 (add immediate) and code 4 (subtract immediate) use the 8-bit immediate sign-extended to 32 bits.
- R5: Codes 6, 8 and 10 set A to A and rn, A or rn and A xor rn, in that order.
- R6: Codes 7, 9 and 11 perform and, or and xor with the immediate zero-extended to 32 bits.
- R7: Code 5 shifts A right by exactly one bit and copies bit 31 into itself.
- R8: Code 12 copies rn into A. Code 13 loads the sign-extended immediate into A.
- R9: Codes 14, 15 and 16 write the sign-extended immediate into A[31:8], A[31:16] and A[31:24] respectively. The bits below each field keep their value.
- R10: Code 17 (store) drives `wb_data_o` equal to A and raises `wb_we_o` while `we_i` is 1. A is unchanged. `wb_we_o` is 0 for every other code.
- R11: `zero_o` equals 1 exactly when A is 0, and `neg_o` equals A[31]. Both are registered and track A in the same cycle that A changes.
- R12: Code 0 and codes 18 to 31 leave A unchanged even when `we_i` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| we_i | input | 1 | Qualifies the update in this cycle |
| op_code_i | input | 5 | Decoded operation select |
| rn_i | input | 32 | Register-file operand |
| imm_i | input | 8 | Immediate operand |
| acc_o | output | 32 | Accumulator value |
| zero_o | output | 1 | Registered flag, accumulator is zero |
| neg_o | output | 1 | Registered flag, accumulator bit 31 |
| wb_data_o | output | 32 | Write-back data for store-to-register |
| wb_we_o | output | 1 | Write-back strobe |

## Verification
The bench builds the block with a 32-bit data width, an 8-bit immediate and the default subtractor variant. With this geometry the three partial loads reach byte lanes 1, 2 and 3. A constant can then be assembled lane by lane and later overwritten by a lower-lane load with a negative immediate. At 32 bits, a wrap past all ones, a shift that must keep a set sign bit, and the difference between sign and zero extension of an immediate with its top bit set each produce a distinct, visible result word.

// File: rtl/acc_pkg.sv
package acc_pkg;

   typedef enum logic [4:0] {
      OP_NOP  = 5'd0,
      OP_ADD  = 5'd1,
      OP_ADDI = 5'd2,
      OP_SUB  = 5'd3,
      OP_SUBI = 5'd4,
      OP_SRA  = 5'd5,
      OP_AND  = 5'd6,
      OP_ANDI = 5'd7,
      OP_OR   = 5'd8,
      OP_ORI  = 5'd9,
      OP_XOR  = 5'd10,
      OP_XORI = 5'd11,
      OP_LD   = 5'd12,
      OP_LDI  = 5'd13,
      OP_LDH1 = 5'd14,
      OP_LDH2 = 5'd15,
      OP_LDH3 = 5'd16,
      OP_ST   = 5'd17
   } op_e;

   typedef enum logic [2:0] {
      FN_PASS = 3'd0,
      FN_ADD  = 3'd1,
      FN_SUB  = 3'd2,
      FN_AND  = 3'd3,
      FN_OR   = 3'd4,
      FN_XOR  = 3'd5,
      FN_SRA  = 3'd6
   } alu_fn_e;

   typedef struct packed {
      alu_fn_e    fn;
      logic       use_imm;
      logic       imm_sext;
      logic       wr_acc;
      logic       lane_ld;
      logic [1:0] lane;
      logic       store;
   } ctl_t;

endpackage

// File: rtl/acc_decode.sv
module acc_decode
   import acc_pkg::*;
(
   input  logic [4:0] op_code_i,
   output ctl_t       ctl_o
);

   always_comb begin
      ctl_o          = '0;
      ctl_o.fn       = FN_PASS;
      ctl_o.imm_sext = 1'b1;
      case (op_code_i)
         OP_ADD:  begin ctl_o.fn = FN_ADD; ctl_o.wr_acc = 1'b1; end
         OP_ADDI: begin ctl_o.fn = FN_ADD; ctl_o.use_imm = 1'b1; ctl_o.wr_acc = 1'b1; end
         OP_SUB:  begin ctl_o.fn = FN_SUB; ctl_o.wr_acc = 1'b1; end
         OP_SUBI: begin ctl_o.fn = FN_SUB; ctl_o.use_imm = 1'b1; ctl_o.wr_acc = 1'b1; end
         OP_SRA:  begin ctl_o.fn = FN_SRA; ctl_o.wr_acc = 1'b1; end
         OP_AND:  begin ctl_o.fn = FN_AND; ctl_o.wr_acc = 1'b1; end
         OP_ANDI: begin
            ctl_o.fn = FN_AND; ctl_o.use_imm = 1'b1;
            ctl_o.imm_sext = 1'b0; ctl_o.wr_acc = 1'b1;
         end
         OP_OR:   begin ctl_o.fn = FN_OR; ctl_o.wr_acc = 1'b1; end
         OP_ORI:  begin
            ctl_o.fn = FN_OR; ctl_o.use_imm = 1'b1;
            ctl_o.imm_sext = 1'b0; ctl_o.wr_acc = 1'b1;
         end
         OP_XOR:  begin ctl_o.fn = FN_XOR; ctl_o.wr_acc = 1'b1; end
         OP_XORI: begin
            ctl_o.fn = FN_XOR; ctl_o.use_imm = 1'b1;
            ctl_o.imm_sext = 1'b0; ctl_o.wr_acc = 1'b1;
         end
         OP_LD:   begin ctl_o.fn = FN_PASS; ctl_o.wr_acc = 1'b1; end
         OP_LDI:  begin ctl_o.fn = FN_PASS; ctl_o.use_imm = 1'b1; ctl_o.wr_acc = 1'b1; end
         OP_LDH1: begin ctl_o.lane_ld = 1'b1; ctl_o.lane = 2'd1; ctl_o.wr_acc = 1'b1; end
         OP_LDH2: begin ctl_o.lane_ld = 1'b1; ctl_o.lane = 2'd2; ctl_o.wr_acc = 1'b1; end
         OP_LDH3: begin ctl_o.lane_ld = 1'b1; ctl_o.lane = 2'd3; ctl_o.wr_acc = 1'b1; end
         OP_ST:   begin ctl_o.store = 1'b1; end
         default: ctl_o.wr_acc = 1'b0;
      endcase
   end

endmodule

// File: rtl/acc_imm_ext.sv
module acc_imm_ext #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] imm_sx_o,
   output logic [DATA_W-1:0] imm_zx_o
);

   localparam int PAD_W = DATA_W - IMM_W;

   assign imm_sx_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
   assign imm_zx_o = {{PAD_W{1'b0}}, imm_i};

endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int SUB_STYLE = 0
) (
   input  alu_fn_e           fn_i,
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] b_i,
   output logic [DATA_W-1:0] y_o
);

   logic [DATA_W-1:0] diff;

   generate
      if (SUB_STYLE == 0) begin : g_sub_direct
         assign diff = a_i - b_i;
      end else begin : g_sub_invert
         assign diff = a_i + ~b_i + {{(DATA_W-1){1'b0}}, 1'b1};
      end
   endgenerate

   always_comb begin
      case (fn_i)
         FN_ADD:  y_o = a_i + b_i;
         FN_SUB:  y_o = diff;
         FN_AND:  y_o = a_i & b_i;
         FN_OR:   y_o = a_i | b_i;
         FN_XOR:  y_o = a_i ^ b_i;
         FN_SRA:  y_o = {a_i[DATA_W-1], a_i[DATA_W-1:1]};
         default: y_o = b_i;
      endcase
   end

endmodule

// File: rtl/acc_lane_merge.sv
module acc_lane_merge #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input  logic [DATA_W-1:0] a_i,
   input  logic [DATA_W-1:0] imm_sx_i,
   input  logic [1:0]        lane_i,
   output logic [DATA_W-1:0] y_o
);

   logic [DATA_W-1:0] cand [4];

   assign cand[0] = imm_sx_i;

   generate
      for (genvar l = 1; l < 4; l++) begin : g_lane
         localparam int LOW_W = l * IMM_W;
         localparam int TOP_W = DATA_W - LOW_W;
         assign cand[l] = {imm_sx_i[TOP_W-1:0], a_i[LOW_W-1:0]};
      end
   endgenerate

   assign y_o = cand[lane_i];

endmodule

// File: rtl/acc_exec.sv
module acc_exec
   import acc_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 8,
   parameter int SUB_STYLE = 0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we_i,
   input  logic [4:0]        op_code_i,
   input  logic [DATA_W-1:0] rn_i,
   input  logic [IMM_W-1:0]  imm_i,
   output logic [DATA_W-1:0] acc_o,
   output logic              zero_o,
   output logic              neg_o,
   output logic [DATA_W-1:0] wb_data_o,
   output logic              wb_we_o
);

   localparam int LANES = DATA_W / IMM_W;

   generate
      if ((DATA_W % IMM_W) != 0) begin : g_bad_ratio
         $error("acc_exec: DATA_W must be a multiple of IMM_W");
      end
      if (LANES < 4) begin : g_bad_lanes
         $error("acc_exec: at least four immediate lanes are required");
      end
      if (SUB_STYLE != 0 && SUB_STYLE != 1) begin : g_bad_sub
         $error("acc_exec: SUB_STYLE must be 0 or 1");
      end
   endgenerate

   ctl_t              ctl;
   logic [DATA_W-1:0] imm_sx, imm_zx, operand, alu_y, lane_y, acc_next;
   logic [DATA_W-1:0] acc_q;
   logic              zero_q, neg_q, upd;

   acc_decode u_dec (.op_code_i(op_code_i), .ctl_o(ctl));

   acc_imm_ext #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_ext (
      .imm_i(imm_i), .imm_sx_o(imm_sx), .imm_zx_o(imm_zx)
   );

   always_comb begin
      if (!ctl.use_imm)      operand = rn_i;
      else if (ctl.imm_sext) operand = imm_sx;
      else                   operand = imm_zx;
   end

   acc_alu #(.DATA_W(DATA_W), .SUB_STYLE(SUB_STYLE)) u_alu (
      .fn_i(ctl.fn), .a_i(acc_q), .b_i(operand), .y_o(alu_y)
   );

   acc_lane_merge #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_lane (
      .a_i(acc_q), .imm_sx_i(imm_sx), .lane_i(ctl.lane), .y_o(lane_y)
   );

   assign acc_next = ctl.lane_ld ? lane_y : alu_y;
   assign upd      = we_i && ctl.wr_acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         zero_q <= 1'b1;
         neg_q  <= 1'b0;
      end else if (upd) begin
         acc_q  <= acc_next;
         zero_q <= (acc_next == '0);
         neg_q  <= acc_next[DATA_W-1];
      end
   end

   assign acc_o     = acc_q;
   assign zero_o    = zero_q;
   assign neg_o     = neg_q;
   assign wb_data_o = acc_q;
   assign wb_we_o   = we_i && ctl.store;

endmodule

// File: rtl/acc_exec_chk.sv
module acc_exec_chk #(
   parameter int DATA_W = 32,
   parameter int IMM_W  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              we_i,
   input logic [4:0]        op_code_i,
   input logic [DATA_W-1:0] acc_o,
   input logic              zero_o,
   input logic              neg_o,
   input logic [DATA_W-1:0] wb_data_o,
   input logic              wb_we_o
);

   localparam int LOW3 = 3 * IMM_W;

   a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
      !we_i |=> $stable(acc_o));

   a_r10_store_keeps_acc: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && op_code_i == 5'd17) |=> $stable(acc_o));

   a_r10_wb_matches_acc: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we_o |-> (wb_data_o == acc_o));

   a_r10_wb_only_store: assert property (@(posedge clk) disable iff (!rst_n)
      wb_we_o |-> (we_i && op_code_i == 5'd17));

   a_r11_zero_flag: assert property (@(posedge clk) disable iff (!rst_n)
      zero_o == (acc_o == '0));

   a_r11_sign_flag: assert property (@(posedge clk) disable iff (!rst_n)
      neg_o == acc_o[DATA_W-1]);

   a_r7_sra_keeps_msb: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && op_code_i == 5'd5) |=> (acc_o[DATA_W-1] == $past(acc_o[DATA_W-1])));

   a_r9_lane3_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && op_code_i == 5'd16) |=> (acc_o[LOW3-1:0] == $past(acc_o[LOW3-1:0])));

   a_r12_unused_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (we_i && (op_code_i == 5'd0 || op_code_i > 5'd17)) |=> $stable(acc_o));

endmodule

bind acc_exec acc_exec_chk #(.DATA_W(DATA_W), .IMM_W(IMM_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .we_i(we_i), .op_code_i(op_code_i),
   .acc_o(acc_o), .zero_o(zero_o), .neg_o(neg_o),
   .wb_data_o(wb_data_o), .wb_we_o(wb_we_o)
);

// File: tb/acc_exec_tb_top.sv
`timescale 1ns/100ps
module acc_exec_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        we_i = 1'b0;
   logic [4:0]  op_code_i = 5'd0;
   logic [31:0] rn_i = '0;
   logic [7:0]  imm_i = '0;
   logic [31:0] acc_o, wb_data_o;
   logic        zero_o, neg_o, wb_we_o;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   acc_exec dut_i (
      .clk(clk), .rst_n(rst_n), .we_i(we_i), .op_code_i(op_code_i),
      .rn_i(rn_i), .imm_i(imm_i), .acc_o(acc_o), .zero_o(zero_o),
      .neg_o(neg_o), .wb_data_o(wb_data_o), .wb_we_o(wb_we_o)
   );

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   // drive at a falling edge, let one rising edge pass, return at the next falling edge
   task automatic apply(input logic [4:0] op, input logic [31:0] rn,
                        input logic [7:0] imm, input logic we);
      @(negedge clk);
      op_code_i = op; rn_i = rn; imm_i = imm; we_i = we;
      @(negedge clk);
      we_i = 1'b0;
   endtask

   task automatic set_acc(input logic [31:0] v);
      apply(5'd12, v, 8'h00, 1'b1);
   endtask

   task automatic t_reset();
      check("R1 acc", acc_o, 32'h0);
      check("R1 zero", {31'b0, zero_o}, 32'h1);
      check("R1 neg", {31'b0, neg_o}, 32'h0);
   endtask

   task automatic t_hold();
      set_acc(32'h1234_5678);
      apply(5'd1, 32'h1, 8'h00, 1'b0);
      check("R2 add with we low", acc_o, 32'h1234_5678);
      apply(5'd13, 32'h0, 8'h7F, 1'b0);
      check("R2 loadi with we low", acc_o, 32'h1234_5678);
   endtask

   task automatic t_add_sub();
      set_acc(32'h0000_0010);
      apply(5'd1, 32'h0000_0005, 8'h00, 1'b1);
      check("R3 add", acc_o, 32'h0000_0015);
      apply(5'd3, 32'h0000_0020, 8'h00, 1'b1);
      check("R3 sub below zero", acc_o, 32'hFFFF_FFF5);
      set_acc(32'hFFFF_FFFF);
      apply(5'd1, 32'h0000_0001, 8'h00, 1'b1);
      check("R3 add wrap", acc_o, 32'h0);
      check("R11 zero after wrap", {31'b0, zero_o}, 32'h1);
   endtask

   task automatic t_imm_arith();
      set_acc(32'd5);
      apply(5'd4, 32'h0, 8'hFE, 1'b1);
      check("R4 subi negative imm", acc_o, 32'd7);
      apply(5'd2, 32'h0, 8'hFF, 1'b1);
      check("R4 addi negative imm", acc_o, 32'd6);
      apply(5'd2, 32'h0, 8'h7F, 1'b1);
      check("R4 addi positive imm", acc_o, 32'd133);
   endtask

   task automatic t_logic_reg();
      set_acc(32'hF0F0_F0F0);
      apply(5'd6, 32'hFF00_FF00, 8'h00, 1'b1);
      check("R5 and", acc_o, 32'hF000_F000);
      apply(5'd8, 32'h0000_00FF, 8'h00, 1'b1);
      check("R5 or", acc_o, 32'hF000_F0FF);
      apply(5'd10, 32'hFFFF_FFFF, 8'h00, 1'b1);
      check("R5 xor", acc_o, 32'h0FFF_0F00);
   endtask

   task automatic t_logic_imm();
      set_acc(32'hFFFF_FFFF);
      apply(5'd7, 32'h0, 8'h80, 1'b1);
      check("R6 andi zero-extended", acc_o, 32'h0000_0080);
      set_acc(32'h0);
      apply(5'd9, 32'h0, 8'h80, 1'b1);
      check("R6 ori zero-extended", acc_o, 32'h0000_0080);
      set_acc(32'hFFFF_0000);
      apply(5'd11, 32'h0, 8'hFF, 1'b1);
      check("R6 xori zero-extended", acc_o, 32'hFFFF_00FF);
   endtask

   task automatic t_sra();
      set_acc(32'h8000_0003);
      apply(5'd5, 32'h0, 8'h00, 1'b1);
      check("R7 sra negative", acc_o, 32'hC000_0001);
      apply(5'd5, 32'h0, 8'h00, 1'b1);
      check("R7 sra negative twice", acc_o, 32'hE000_0000);
      set_acc(32'h4000_0001);
      apply(5'd5, 32'h0, 8'h00, 1'b1);
      check("R7 sra positive", acc_o, 32'h2000_0000);
   endtask

   task automatic t_loads();
      apply(5'd12, 32'hDEAD_BEEF, 8'h00, 1'b1);
      check("R8 load register", acc_o, 32'hDEAD_BEEF);
      apply(5'd13, 32'h0, 8'h80, 1'b1);
      check("R8 loadi negative", acc_o, 32'hFFFF_FF80);
      check("R11 sign flag", {31'b0, neg_o}, 32'h1);
      check("R11 zero flag clear", {31'b0, zero_o}, 32'h0);
      apply(5'd13, 32'h0, 8'h35, 1'b1);
      check("R8 loadi positive", acc_o, 32'h0000_0035);
   endtask

   task automatic t_lanes();
      apply(5'd13, 32'h0, 8'h44, 1'b1);
      apply(5'd14, 32'h0, 8'h33, 1'b1);
      check("R9 lane 1", acc_o, 32'h0000_3344);
      apply(5'd15, 32'h0, 8'h22, 1'b1);
      check("R9 lane 2", acc_o, 32'h0022_3344);
      apply(5'd16, 32'h0, 8'h91, 1'b1);
      check("R9 lane 3", acc_o, 32'h9122_3344);
      apply(5'd14, 32'h0, 8'hF0, 1'b1);
      check("R9 lane 1 negative", acc_o, 32'hFFFF_F044);
      apply(5'd15, 32'h0, 8'h01, 1'b1);
      check("R9 lane 2 over negative", acc_o, 32'h0001_F044);
   endtask

   task automatic t_store();
      set_acc(32'hCAFE_0001);
      @(negedge clk);
      op_code_i = 5'd17; rn_i = 32'h5555_5555; imm_i = 8'hAA; we_i = 1'b1;
      #1;
      check("R10 wb strobe", {31'b0, wb_we_o}, 32'h1);
      check("R10 wb data", wb_data_o, 32'hCAFE_0001);
      @(negedge clk);
      we_i = 1'b0;
      check("R10 acc unchanged", acc_o, 32'hCAFE_0001);
      op_code_i = 5'd1;
      we_i = 1'b1;
      #1;
      check("R10 no strobe for add", {31'b0, wb_we_o}, 32'h0);
      we_i = 1'b0;
   endtask

   task automatic t_unused();
      set_acc(32'h0BAD_F00D);
      apply(5'd0, 32'hFFFF_FFFF, 8'hFF, 1'b1);
      check("R12 code 0", acc_o, 32'h0BAD_F00D);
      apply(5'd20, 32'hFFFF_FFFF, 8'hFF, 1'b1);
      check("R12 code 20", acc_o, 32'h0BAD_F00D);
      apply(5'd31, 32'h0, 8'h00, 1'b1);
      check("R12 code 31", acc_o, 32'h0BAD_F00D);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_hold();
      t_add_sub();
      t_imm_arith();
      t_logic_reg();
      t_logic_imm();
      t_sra();
      t_loads();
      t_lanes();
      t_store();
      t_unused();
      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

endmodule